// File: doc/BRIEF.md
# Slave-Mode Up/Down Timer with Quadrature Decoding

This block is a timer counter whose counting source and gating come from one 3-bit mode field. The counter can step on every clock cycle, follow a two-phase quadrature encoder, or respond to a trigger line taken from one of several parent sources. In trigger-driven modes the trigger can reload the counter, gate it, start it, or act as its clock. A preset register sets the limit of the count. A pulse marks each wrap, and the counter folds back to its start value on that pulse.

The block is configured and read through a flat register port. Writes take effect at the clock edge. Reads are combinational from the address. The encoder and trigger pins pass through a two-flop synchronizer and one extra stage for edge detection. Because of this, a pin change reaches the counter on the third rising edge after it is applied.

Top module: `slave_timer_qenc`

## Requirements
- R1: After reset the control, mode and count registers read 0, the preset register reads all ones, and `wrap_evt` is low.
- R2: The register map is: control at 0x00, mode at 0x08, count at 0x24 and preset at 0x2C. Control bit 0 is enable, bit 4 is direction (1 = down) and bit 7 is preload enable. Mode bits [2:0] are the mode code and bits [6:4] are the trigger select. Unmapped addresses read 0.
- R3: Mode 0 (internal tick) with enable set and direction up advances the counter once per cycle. It runs 0..preset. On the step after preset it returns to 0, and `wrap_evt` is high for that one cycle.
- R4: With direction down the counter runs from preset toward 0. On the step after 0 it reloads the preset value, and `wrap_evt` pulses.
- R5: Mode 1 steps only on a change of B while A is unchanged. The step is up when the new B equals A and down otherwise.
- R6: Mode 2 steps only on a change of A while B is unchanged. The step is up when the new A differs from B and down otherwise.
- R7: Mode 3 steps on a lone change of either input, using the R5 or R6 rule. A transition in which both inputs change together is ignored.
- R8: In modes 1 to 3 the direction bit shows the direction of the last encoder step, and control writes to it have no effect.
- R9: Mode 4 counts like mode 0, and a rising edge of the selected trigger reloads the start value: 0 when counting up, preset when counting down.
- R10: Mode 5 advances once per cycle only while the selected trigger is high. While the trigger is low the count holds and is not cleared.
- R11: Mode 6 sets the enable bit on a rising edge of the selected trigger and counts from the held value from then on.
- R12: Mode 7 advances once per rising edge of the selected trigger. Select values 1..4 pick trigger inputs 0..3, and 0 means no trigger. Writing a nonzero select that differs from the current one forces the mode to 7 and sets enable.
- R13: With preload off a preset write takes effect at once. With preload on, the new preset takes effect only at the next wrap.
- R14: A change on an encoder or trigger pin affects the count at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Combinational read data for `bus_addr` |
| trig_in | input | NTRIG | Parent trigger sources |
| enc_a | input | 1 | Quadrature input A |
| enc_b | input | 1 | Quadrature input B |
| wrap_evt | output | 1 | One-cycle pulse on each counter wrap |

## Verification
A register write lands on the next rising edge, and a read is valid within the same cycle. In the internal-tick modes the counter moves on the edge after the one that sets enable, and `wrap_evt` rises on the same edge as the wrap. A pin change moves the count on the third edge after it is applied. Trigger-start takes one edge more, because enable must be set first. The bench drives stimulus at the falling edge and waits exactly those edge counts. It samples half a nanosecond after a falling edge. Where latency is the point of a check, it confirms the count is still unchanged one edge before the result is due.

// File: rtl/slave_timer_qenc.sv
`timescale 1ns/1ps
module slave_timer_qenc #(
  parameter int CW    = 16,
  parameter int NTRIG = 4,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [CW-1:0]    bus_wdata,
  output logic [CW-1:0]    bus_rdata,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic             wrap_evt
);

  localparam int SW  = $clog2(NTRIG + 1);
  localparam int NIN = NTRIG + 2;
  localparam int IA  = NTRIG;
  localparam int IB  = NTRIG + 1;

  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_MODE = AW'(8'h08);
  localparam logic [AW-1:0] A_CNT  = AW'(8'h24);
  localparam logic [AW-1:0] A_ARR  = AW'(8'h2C);

  localparam logic [2:0] M_INT  = 3'd0;
  localparam logic [2:0] M_ENC1 = 3'd1;
  localparam logic [2:0] M_ENC2 = 3'd2;
  localparam logic [2:0] M_ENC3 = 3'd3;
  localparam logic [2:0] M_RST  = 3'd4;
  localparam logic [2:0] M_GATE = 3'd5;
  localparam logic [2:0] M_TSTA = 3'd6;
  localparam logic [2:0] M_TCLK = 3'd7;

  logic [NIN-1:0] s1_q, s2_q, s3_q;
  logic [CW-1:0]  cnt_q, arr_reg, arr_act;
  logic [2:0]     mode_q;
  logic [SW-1:0]  sel_q;
  logic           en_q, dir_q, arpe_q, evt_q;

  logic wr_ctrl, wr_mode, wr_cnt, wr_arr;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_mode = bus_wr && bus_addr == A_MODE;
  assign wr_cnt  = bus_wr && bus_addr == A_CNT;
  assign wr_arr  = bus_wr && bus_addr == A_ARR;

  logic [SW-1:0] wsel;
  logic          attach;
  assign wsel   = bus_wdata[4 +: SW];
  assign attach = wr_mode && wsel != '0 && wsel <= SW'(NTRIG) && wsel != sel_q;

  logic trg_lvl, trg_old, trg_rise;
  always_comb begin
    trg_lvl = 1'b0;
    trg_old = 1'b0;
    for (int i = 0; i < NTRIG; i++)
      if (sel_q == SW'(i + 1)) begin
        trg_lvl = s2_q[i];
        trg_old = s3_q[i];
      end
  end
  assign trg_rise = trg_lvl & ~trg_old;

  logic a_now, b_now, a_chg, b_chg, enc_mode, enc_step, enc_down;
  assign a_now    = s2_q[IA];
  assign b_now    = s2_q[IB];
  assign a_chg    = s2_q[IA] ^ s3_q[IA];
  assign b_chg    = s2_q[IB] ^ s3_q[IB];
  assign enc_mode = mode_q == M_ENC1 || mode_q == M_ENC2 || mode_q == M_ENC3;

  always_comb begin
    enc_step = 1'b0;
    enc_down = dir_q;
    if ((mode_q == M_ENC1 || mode_q == M_ENC3) && b_chg && !a_chg) begin
      enc_step = 1'b1;
      enc_down = a_now ^ b_now;
    end else if ((mode_q == M_ENC2 || mode_q == M_ENC3) && a_chg && !b_chg) begin
      enc_step = 1'b1;
      enc_down = ~(a_now ^ b_now);
    end
  end

  logic step, cnt_dn, reload_hit, wrap;
  logic [CW-1:0] arr_nxt;
  always_comb begin
    case (mode_q)
      M_ENC1, M_ENC2, M_ENC3: step = en_q & enc_step;
      M_GATE:                 step = en_q & trg_lvl;
      M_TCLK:                 step = en_q & trg_rise;
      default:                step = en_q;
    endcase
  end
  assign cnt_dn     = enc_mode ? enc_down : dir_q;
  assign reload_hit = mode_q == M_RST && trg_rise;
  assign wrap       = step && !reload_hit && !wr_cnt &&
                      (cnt_dn ? cnt_q == '0 : cnt_q >= arr_act);
  assign arr_nxt    = arpe_q ? arr_reg : arr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= '0;
      s2_q    <= '0;
      s3_q    <= '0;
      cnt_q   <= '0;
      arr_reg <= '1;
      arr_act <= '1;
      mode_q  <= M_INT;
      sel_q   <= '0;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      arpe_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      s1_q  <= {enc_b, enc_a, trig_in};
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      evt_q <= wrap;

      if (wr_ctrl)                         en_q <= bus_wdata[0];
      else if (attach)                     en_q <= 1'b1;
      else if (mode_q == M_TSTA && trg_rise) en_q <= 1'b1;

      if (wr_ctrl) arpe_q <= bus_wdata[7];

      if (enc_mode) begin
        if (step) dir_q <= enc_down;
      end else if (wr_ctrl) begin
        dir_q <= bus_wdata[4];
      end

      if (wr_mode) begin
        mode_q <= attach ? M_TCLK : bus_wdata[2:0];
        sel_q  <= wsel;
      end

      if (wr_cnt)          cnt_q <= bus_wdata;
      else if (reload_hit) cnt_q <= dir_q ? arr_act : '0;
      else if (wrap)       cnt_q <= cnt_dn ? arr_nxt : '0;
      else if (step)       cnt_q <= cnt_dn ? cnt_q - 1'b1 : cnt_q + 1'b1;

      if (wr_arr) arr_reg <= bus_wdata;

      if (wr_arr && !arpe_q)   arr_act <= bus_wdata;
      else if (wrap && arpe_q) arr_act <= arr_reg;
    end
  end

  assign wrap_evt = evt_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = CW'({arpe_q, 2'b00, dir_q, 3'b000, en_q});
      A_MODE:  bus_rdata = CW'({sel_q, 1'b0, mode_q});
      A_CNT:   bus_rdata = cnt_q;
      A_ARR:   bus_rdata = arr_reg;
      default: bus_rdata = '0;
    endcase
  end

  AST_EVT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (evt_q && !$past(wr_arr)) |-> (cnt_q == '0 || cnt_q == arr_act)); // R3
  AST_TSEL_AUTO: assert property (@(posedge clk) disable iff (!rst_n) attach |=> (mode_q == M_TCLK && en_q)); // R12
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == M_GATE && !trg_lvl && !wr_cnt) |=> $stable(cnt_q)); // R10
  AST_ENC_DIR_RO: assert property (@(posedge clk) disable iff (!rst_n) (enc_mode && !enc_step) |=> $stable(dir_q)); // R8
  AST_RST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) (reload_hit && !wr_cnt) |=> (cnt_q == ($past(dir_q) ? $past(arr_act) : '0))); // R9

endmodule

// File: tb/sim_slave_timer_qenc.sv
`timescale 1ns/1ps
module sim_slave_timer_qenc;
  localparam int CW = 16;
  localparam int NT = 4;
  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h08, A_CNT = 8'h24, A_ARR = 8'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]    bus_addr = 8'h00;
  logic          bus_wr = 1'b0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [NT-1:0] trig = '0;
  logic          ea = 1'b0, eb = 1'b0;
  logic          evt;

  int n_run = 0, n_fail = 0;

  slave_timer_qenc #(.CW(CW), .NTRIG(NT), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig),
    .enc_a(ea), .enc_b(eb), .wrap_evt(evt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [CW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = 32'(bus_rdata);
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int exp;
    int seq [16] = '{1, 3, 2, 0, 2, 3, 1, 0, 3, 0, 1, 0, 2, 0, 1, 3};
    int pre3 [4] = '{0, 1, 2, 5};
    int pre4 [3] = '{0, 3, 6};
    int dur [3] = '{3, 7, 12};

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rdchk("R1 ctrl", A_CTRL, 0);
    rdchk("R1 mode", A_MODE, 0);
    rdchk("R1 count", A_CNT, 0);
    rdchk("R1 preset", A_ARR, 32'hFFFF);
    chk("R1 event", {31'b0, evt}, 0);

    // R2 register map
    wr(A_CTRL, 16'h0090); rdchk("R2 ctrl bits", A_CTRL, 32'h90);
    wr(A_MODE, 16'h0005); rdchk("R2 mode field", A_MODE, 5);
    wr(A_CNT, 16'd1234);  rdchk("R2 count", A_CNT, 1234);
    wr(A_ARR, 16'h02C5);  rdchk("R2 preset", A_ARR, 32'h2C5);
    rdchk("R2 unmapped", 8'h10, 0);
    wr(A_CTRL, 0); wr(A_MODE, 0);

    // R3 up counting sweep (preset written with preload off: R13 immediate)
    foreach (pre3[p]) begin
      wr(A_ARR, 16'(pre3[p])); wr(A_CNT, 0); wr(A_CTRL, 16'h0001);
      for (int k = 1; k <= 2 * pre3[p] + 3; k++) begin
        idle(1);
        rd(A_CNT, v);
        chk("R3 up count", v, k % (pre3[p] + 1));
        chk("R3 up event", {31'b0, evt}, (k % (pre3[p] + 1)) == 0);
      end
      wr(A_CTRL, 0);
    end

    // R4 down counting sweep
    foreach (pre4[p]) begin
      wr(A_ARR, 16'(pre4[p])); wr(A_CNT, 16'(pre4[p])); wr(A_CTRL, 16'h0011);
      for (int k = 1; k <= 2 * pre4[p] + 3; k++) begin
        idle(1);
        rd(A_CNT, v);
        chk("R4 down count", v, pre4[p] - (k % (pre4[p] + 1)));
        chk("R4 down event", {31'b0, evt}, (k % (pre4[p] + 1)) == 0);
      end
      wr(A_CTRL, 0);
    end

    // R5 R6 R7 R8 encoder modes
    for (int m = 1; m <= 3; m++) begin
      logic pa, pb;
      wr(A_CTRL, 0); ea = 1'b0; eb = 1'b0; idle(3);
      wr(A_ARR, 16'd1000); wr(A_CNT, 16'd500); wr(A_MODE, 16'(m)); wr(A_CTRL, 16'h0001);
      exp = 500; pa = 1'b0; pb = 1'b0;
      for (int i = 0; i < 16; i++) begin
        logic na, nb;
        int d;
        na = seq[i][0]; nb = seq[i][1];
        d = 0;
        if ((m == 1 || m == 3) && nb != pb && na == pa) d = (nb == na) ? 1 : -1;
        if ((m == 2 || m == 3) && na != pa && nb == pb) d = (na != nb) ? 1 : -1;
        ea = na; eb = nb;
        idle(3);
        exp += d;
        rd(A_CNT, v);
        case (m)
          1: chk("R5 enc1 count", v, exp);
          2: chk("R6 enc2 count", v, exp);
          default: chk("R7 enc3 count", v, exp);
        endcase
        if (d != 0) begin
          rd(A_CTRL, v);
          chk("R8 derived direction", v[4], d < 0);
        end
        pa = na; pb = nb;
      end
      rd(A_CTRL, v);
      begin
        logic dcur;
        dcur = v[4];
        wr(A_CTRL, {11'b0, ~dcur, 4'b0001});
        rd(A_CTRL, v);
        chk("R8 direction write ignored", v[4], dcur);
      end
      rdchk("R8 count unchanged by write", A_CNT, exp);
      wr(A_CTRL, 0); wr(A_MODE, 0);
    end
    ea = 1'b0; eb = 1'b0; idle(3);

    // R9 reset mode
    wr(A_MODE, 16'h0010); wr(A_CTRL, 0); wr(A_MODE, 16'h0014);
    wr(A_ARR, 16'd77); wr(A_CNT, 16'd50);
    trig[0] = 1'b1; idle(3);
    rdchk("R9 reload up start", A_CNT, 0);
    trig[0] = 1'b0;
    wr(A_CTRL, 16'h0010); wr(A_CNT, 16'd5);
    trig[0] = 1'b1; idle(2);
    rdchk("R14 not yet at edge 2", A_CNT, 5);
    idle(1);
    rdchk("R9 R14 reload preset at edge 3", A_CNT, 77);
    trig[0] = 1'b0; idle(3);

    // R10 gated mode
    wr(A_CTRL, 0); wr(A_MODE, 16'h0020); wr(A_MODE, 16'h0025);
    wr(A_CNT, 0); wr(A_CTRL, 16'h0001);
    idle(6);
    rdchk("R10 gate low holds", A_CNT, 0);
    exp = 0;
    foreach (dur[j]) begin
      trig[1] = 1'b1; idle(dur[j]);
      trig[1] = 1'b0; idle(6);
      exp += dur[j];
      rdchk("R10 counts while high", A_CNT, exp);
    end
    idle(5);
    rdchk("R10 not cleared when low", A_CNT, exp);

    // R11 trigger start
    wr(A_CTRL, 0); wr(A_MODE, 16'h0030); wr(A_CTRL, 0); wr(A_MODE, 16'h0036);
    wr(A_CNT, 16'd20);
    idle(4);
    rdchk("R11 idle before trigger", A_CNT, 20);
    trig[2] = 1'b1; idle(3);
    rdchk("R11 start keeps value", A_CNT, 20);
    rdchk("R11 enable set", A_CTRL, 1);
    for (int k = 1; k <= 4; k++) begin
      idle(1);
      rdchk("R11 counting after start", A_CNT, 20 + k);
    end
    trig[2] = 1'b0;
    wr(A_CTRL, 0);

    // R12 trigger clock with select
    wr(A_MODE, 0); wr(A_CNT, 0); idle(3);
    wr(A_MODE, 16'h0040);
    rdchk("R12 mode forced", A_MODE, 32'h47);
    rdchk("R12 enable forced", A_CTRL, 1);
    trig[3] = 1'b1; idle(2);
    rdchk("R14 trigger edge 2", A_CNT, 0);
    idle(1);
    rdchk("R12 R14 trigger edge 3", A_CNT, 1);
    trig[3] = 1'b0; idle(2);
    for (int p = 0; p < 4; p++) begin
      trig[3] = 1'b1; idle(2); trig[3] = 1'b0; idle(2);
    end
    idle(3);
    rdchk("R12 one per rising edge", A_CNT, 5);
    for (int p = 0; p < 3; p++) begin
      trig[0] = 1'b1; idle(2); trig[0] = 1'b0; idle(2);
    end
    idle(3);
    rdchk("R12 unselected ignored", A_CNT, 5);
    wr(A_MODE, 16'h0007);
    for (int p = 0; p < 3; p++) begin
      trig[3] = 1'b1; idle(2); trig[3] = 1'b0; idle(2);
    end
    idle(3);
    rdchk("R12 detached ignored", A_CNT, 5);

    // R13 preload
    wr(A_CTRL, 0); wr(A_MODE, 0);
    wr(A_ARR, 16'd3); wr(A_CTRL, 16'h0080); wr(A_ARR, 16'd5);
    rdchk("R13 preset readback", A_ARR, 5);
    wr(A_CNT, 0); wr(A_CTRL, 16'h0081);
    for (int k = 1; k <= 16; k++) begin
      int e;
      idle(1);
      e = (k <= 4) ? k % 4 : (k - 4) % 6;
      rd(A_CNT, v);
      chk("R13 deferred preset count", v, e);
      chk("R13 deferred preset event", {31'b0, evt}, k == 4 || (k > 4 && (k - 4) % 6 == 0));
    end
    wr(A_CTRL, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule